// File: doc/BRIEF.md
# Stereo Receive Sample Buffer with Interrupt Combining

This block sits between a serial audio deserializer and the processor bus. The deserializer delivers one sample per channel whenever one is ready, using a valid strobe and a data word for the left channel and another pair for the right channel. Each channel has its own small first-in first-out store. Software drains the stores through a plain synchronous register interface. A read of a channel's data register pops the oldest sample.

The block tracks three live occupancy levels per channel: full, at least half full, and not empty. It also keeps sticky flags for two error cases. An overrun is a sample that arrives while the store is full. An underrun is a read from an empty store. A status register gathers the ten conditions. Any write to that register clears the four sticky flags. A mask register picks which conditions drive the single level-sensitive interrupt request. A mask bit of 0 enables its condition.

The register word index on `bus_addr_i` selects the register: 0 is left data, 1 is right data, 2 is status, 3 is mask. Read data is registered. It appears on `bus_rdata_o` in the cycle after the request. In every cycle that follows a non-read, it is zero.

Top module: `stereo_rx_irq_ctrl`

## Requirements
- R1: Each channel stores up to 4 samples and returns them in arrival order. A read of address 0 (left) or 1 (right) pops the oldest sample. That sample appears zero-extended on `bus_rdata_o` one cycle after the request. After any cycle with no read, `bus_rdata_o` is zero.
- R2: A read of an empty channel's data register returns zero and leaves the store unchanged. It sets that channel's sticky underrun flag: status bit 1 for left, bit 0 for right.
- R3: A valid strobe that arrives while the channel already holds 4 samples drops the sample. It sets that channel's sticky overrun flag: status bit 3 for left, bit 2 for right. Sticky flags hold until cleared.
- R4: Any write to the status register (address 2), whatever its data, clears all four sticky flags. A flag event in the same cycle as the clearing write leaves that flag set.
- R5: Status bits 4, 5 and 6 are left full (4 held), left half full (at least 2 held) and left not empty. Bits 7, 8 and 9 are the same levels for the right channel. These bits follow the current occupancy and are not sticky.
- R6: The mask register at address 3 holds ten bits that reset to all ones and read back as written. Bits 31:10 of the status and mask registers read as zero, and writes to them have no effect.
- R7: `irq_o` is high exactly when some status bit is 1 and its mask bit is 0.
- R8: After reset both stores are empty, all sticky flags are 0, `bus_rdata_o` is zero and `irq_o` is low.
- R9: A push and a pop on the same channel in the same cycle both take effect. A push into a full store is still dropped even if a pop happens in that cycle. A pop from an empty store is still an underrun even if a push happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_valid_i | input | 1 | Left sample ready strobe |
| l_data_i | input | DW | Left sample |
| r_valid_i | input | 1 | Right sample ready strobe |
| r_data_i | input | DW | Right sample |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW | Register word index |
| bus_wdata_i | input | BW | Write data |
| bus_rdata_o | output | BW | Registered read data |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Every register on a path has one cycle of latency. Read data, sticky flags, occupancy levels and the interrupt all reflect a request or strobe one cycle after it is applied. A clearing write shows at the same point, and `irq_o` follows the registered status and mask with no further delay. The bench drives each stimulus at the falling edge and updates its reference model in that same step. It compares `bus_rdata_o` and `irq_o` one nanosecond after the next rising edge. Status and mask values are checked by reading them back, so each level and flag is observed through the normal read path in the cycle after the event.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int NCH  = 2;
  localparam int CH_L = 0;
  localparam int CH_R = 1;

  // status/mask bit positions (software decodes these)
  localparam int ST_R_UND  = 0;
  localparam int ST_L_UND  = 1;
  localparam int ST_R_OVR  = 2;
  localparam int ST_L_OVR  = 3;
  localparam int ST_L_FULL = 4;
  localparam int ST_L_HALF = 5;
  localparam int ST_L_NEMP = 6;
  localparam int ST_R_FULL = 7;
  localparam int ST_R_HALF = 8;
  localparam int ST_R_NEMP = 9;
  localparam int ST_W      = 10;

  // register word indices
  localparam int ADR_L_DATA = 0;
  localparam int ADR_R_DATA = 1;
  localparam int ADR_STAT   = 2;
  localparam int ADR_MASK   = 3;

  typedef struct packed {
    logic full;
    logic half;
    logic nempty;
  } lvl_t;
endpackage

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DW    = 24,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output lvl_t          level_o,
  output logic          ovr_o,
  output logic          und_o
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int HALF = (DEPTH + 1) / 2;

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          full, empty, do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  // decisions use the occupancy before this cycle's pop
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty;
  assign ovr_o   = push_i && full;
  assign und_o   = pop_i && empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  assign head_o         = mem_q[rd_ptr_q];
  assign level_o.full   = full;
  assign level_o.half   = (cnt_q >= CW'(HALF));
  assign level_o.nempty = !empty;
endmodule

// File: rtl/srx_status.sv
module srx_status
  import srx_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NCH-1:0]       ovr_i,
  input  logic [NCH-1:0]       und_i,
  input  lvl_t [NCH-1:0]       lvl_i,
  input  logic                 clr_i,
  input  logic                 mask_we_i,
  input  logic [ST_W-1:0]      mask_d_i,
  output logic [ST_W-1:0]      status_o,
  output logic [ST_W-1:0]      mask_o,
  output logic                 irq_o
);
  logic [NCH-1:0]  ovr_q, und_q;
  logic [ST_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q  <= '0;
      und_q  <= '0;
      mask_q <= '1;
    end else begin
      // new events win over a same-cycle clear
      ovr_q <= (ovr_q & ~{NCH{clr_i}}) | ovr_i;
      und_q <= (und_q & ~{NCH{clr_i}}) | und_i;
      if (mask_we_i) mask_q <= mask_d_i;
    end
  end

  always_comb begin
    status_o            = '0;
    status_o[ST_R_UND]  = und_q[CH_R];
    status_o[ST_L_UND]  = und_q[CH_L];
    status_o[ST_R_OVR]  = ovr_q[CH_R];
    status_o[ST_L_OVR]  = ovr_q[CH_L];
    status_o[ST_L_FULL] = lvl_i[CH_L].full;
    status_o[ST_L_HALF] = lvl_i[CH_L].half;
    status_o[ST_L_NEMP] = lvl_i[CH_L].nempty;
    status_o[ST_R_FULL] = lvl_i[CH_R].full;
    status_o[ST_R_HALF] = lvl_i[CH_R].half;
    status_o[ST_R_NEMP] = lvl_i[CH_R].nempty;
  end

  assign mask_o = mask_q;
  assign irq_o  = |(status_o & ~mask_q);
endmodule

// File: rtl/stereo_rx_irq_ctrl.sv
module stereo_rx_irq_ctrl
  import srx_pkg::*;
#(
  parameter int DW    = 24,
  parameter int DEPTH = 4,
  parameter int AW    = 2,
  parameter int BW    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          l_valid_i,
  input  logic [DW-1:0] l_data_i,
  input  logic          r_valid_i,
  input  logic [DW-1:0] r_data_i,
  input  logic          bus_req_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [BW-1:0] bus_wdata_i,
  output logic [BW-1:0] bus_rdata_o,
  output logic          irq_o
);
  logic            rd_en, wr_en;
  logic [NCH-1:0]  push_v, pop_v, ovr_v, und_v;
  logic [DW-1:0]   pdata [NCH];
  logic [DW-1:0]   head  [NCH];
  lvl_t [NCH-1:0]  lvl;
  logic [ST_W-1:0] stat_w, mask_w;
  logic [BW-1:0]   rdata_d, rdata_q;
  logic            unused_w;

  assign rd_en = bus_req_i && !bus_we_i;
  assign wr_en = bus_req_i && bus_we_i;

  assign push_v[CH_L] = l_valid_i;
  assign push_v[CH_R] = r_valid_i;
  assign pdata[CH_L]  = l_data_i;
  assign pdata[CH_R]  = r_data_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int ADR = (c == CH_L) ? ADR_L_DATA : ADR_R_DATA;
    assign pop_v[c] = rd_en && (bus_addr_i == AW'(ADR));
    srx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push_v[c]),
      .data_i  (pdata[c]),
      .pop_i   (pop_v[c]),
      .head_o  (head[c]),
      .level_o (lvl[c]),
      .ovr_o   (ovr_v[c]),
      .und_o   (und_v[c])
    );
  end

  srx_status u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ovr_i     (ovr_v),
    .und_i     (und_v),
    .lvl_i     (lvl),
    .clr_i     (wr_en && (bus_addr_i == AW'(ADR_STAT))),
    .mask_we_i (wr_en && (bus_addr_i == AW'(ADR_MASK))),
    .mask_d_i  (bus_wdata_i[ST_W-1:0]),
    .status_o  (stat_w),
    .mask_o    (mask_w),
    .irq_o     (irq_o)
  );

  assign unused_w = ^bus_wdata_i[BW-1:ST_W];

  always_comb begin
    rdata_d = '0;
    if (rd_en) begin
      if (pop_v[CH_L]) begin
        if (lvl[CH_L].nempty) rdata_d[DW-1:0] = head[CH_L];
      end else if (pop_v[CH_R]) begin
        if (lvl[CH_R].nempty) rdata_d[DW-1:0] = head[CH_R];
      end else if (bus_addr_i == AW'(ADR_STAT)) begin
        rdata_d[ST_W-1:0] = stat_w;
      end else if (bus_addr_i == AW'(ADR_MASK)) begin
        rdata_d[ST_W-1:0] = mask_w;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/srx_checker.sv
module srx_checker
  import srx_pkg::*;
#(
  parameter int AW = 2,
  parameter int BW = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            l_valid_i,
  input logic            r_valid_i,
  input logic            bus_req_i,
  input logic            bus_we_i,
  input logic [AW-1:0]   bus_addr_i,
  input logic [BW-1:0]   bus_rdata_o,
  input logic            irq_o,
  input logic [ST_W-1:0] stat_w,
  input logic [ST_W-1:0] mask_w
);
  logic rd_l, wr_stat;
  assign rd_l    = bus_req_i && !bus_we_i && (bus_addr_i == AW'(ADR_L_DATA));
  assign wr_stat = bus_req_i && bus_we_i && (bus_addr_i == AW'(ADR_STAT));

  AST_UND_EMPTY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_l && !stat_w[ST_L_NEMP] |=> stat_w[ST_L_UND] && (bus_rdata_o == '0)); // R2
  AST_OVR_ON_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_valid_i && stat_w[ST_L_FULL] |=> stat_w[ST_L_OVR]); // R3
  AST_STICKY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stat && stat_w[ST_R_OVR] |=> stat_w[ST_R_OVR]); // R3
  AST_CLEAR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat && !l_valid_i && !r_valid_i |=> (stat_w[3:0] == 4'd0)); // R4
  AST_LEVEL_NEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_w[ST_R_FULL] |-> stat_w[ST_R_HALF] && stat_w[ST_R_NEMP]); // R5
  AST_ALL_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_w) |-> !irq_o); // R7
endmodule

bind stereo_rx_irq_ctrl srx_checker #(.AW(AW), .BW(BW)) u_srx_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .l_valid_i   (l_valid_i),
  .r_valid_i   (r_valid_i),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o),
  .stat_w      (stat_w),
  .mask_w      (mask_w)
);

// File: tb/stereo_rx_irq_ctrl_tb.sv
module stereo_rx_irq_ctrl_tb_top;
  localparam int DW = 24;
  localparam int AW = 2;
  localparam int BW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          l_valid_i = 1'b0, r_valid_i = 1'b0;
  logic [DW-1:0] l_data_i = '0, r_data_i = '0;
  logic          bus_req_i = 1'b0, bus_we_i = 1'b0;
  logic [AW-1:0] bus_addr_i = '0;
  logic [BW-1:0] bus_wdata_i = '0;
  logic [BW-1:0] bus_rdata_o;
  logic          irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model
  logic [DW-1:0] mq [2][4];
  int            mc [2];
  logic [3:0]    stk;
  logic [9:0]    msk;

  always #2 clk = ~clk;

  stereo_rx_irq_ctrl #(.DW(DW), .DEPTH(4), .AW(AW), .BW(BW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .l_valid_i(l_valid_i), .l_data_i(l_data_i),
    .r_valid_i(r_valid_i), .r_data_i(r_data_i),
    .bus_req_i(bus_req_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  function automatic logic [9:0] m_stat();
    return {mc[1] > 0, mc[1] >= 2, mc[1] == 4, mc[0] > 0, mc[0] >= 2, mc[0] == 4, stk};
  endfunction

  function automatic logic m_irq();
    return |(m_stat() & ~msk);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // applies one cycle to the model, returns the expected read data
  function automatic logic [31:0] m_apply(input logic lv, input logic [DW-1:0] ld,
                                          input logic rv, input logic [DW-1:0] rd,
                                          input logic req, input logic we,
                                          input logic [1:0] a, input logic [31:0] wd);
    logic [31:0] e = '0;
    logic [9:0]  st_pre = m_stat();
    bit          full_pre [2];
    full_pre[0] = (mc[0] == 4);
    full_pre[1] = (mc[1] == 4);
    if (req && we && a == 2'd2) stk = 4'd0;
    if (req && we && a == 2'd3) msk = wd[9:0];
    if (req && !we) begin
      if (a <= 2'd1) begin
        int c = int'(a);
        if (mc[c] == 0) begin
          stk[(c == 0) ? 1 : 0] = 1'b1;
        end else begin
          e[DW-1:0] = mq[c][0];
          for (int i = 0; i < 3; i++) mq[c][i] = mq[c][i+1];
          mc[c]--;
        end
      end else if (a == 2'd2) e[9:0] = st_pre;
      else e[9:0] = msk;
    end
    if (lv) begin
      if (full_pre[0]) stk[3] = 1'b1;
      else begin mq[0][mc[0]] = ld; mc[0]++; end
    end
    if (rv) begin
      if (full_pre[1]) stk[2] = 1'b1;
      else begin mq[1][mc[1]] = rd; mc[1]++; end
    end
    return e;
  endfunction

  task automatic step(input logic lv, input logic [DW-1:0] ld, input logic rv, input logic [DW-1:0] rd,
                      input logic req, input logic we, input logic [1:0] a, input logic [31:0] wd,
                      input string tag);
    logic [31:0] e;
    @(negedge clk);
    l_valid_i = lv; l_data_i = ld; r_valid_i = rv; r_data_i = rd;
    bus_req_i = req; bus_we_i = we; bus_addr_i = a; bus_wdata_i = wd;
    e = m_apply(lv, ld, rv, rd, req, we, a, wd);
    @(posedge clk);
    #1;
    chk(bus_rdata_o == e, tag, bus_rdata_o, e);
    chk(irq_o == m_irq(), "R7", {31'd0, irq_o}, {31'd0, m_irq()});
  endtask

  task automatic idle(input string tag);
    step(0, '0, 0, '0, 0, 0, 2'd0, '0, tag);
  endtask
  task automatic rd_reg(input logic [1:0] a, input string tag);
    step(0, '0, 0, '0, 1, 0, a, '0, tag);
  endtask
  task automatic wr_reg(input logic [1:0] a, input logic [31:0] wd, input string tag);
    step(0, '0, 0, '0, 1, 1, a, wd, tag);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    mc[0] = 0; mc[1] = 0; stk = '0; msk = '1;
    repeat (3) @(posedge clk);
    #1;
    chk(bus_rdata_o == '0, "R8", bus_rdata_o, '0);
    chk(irq_o == 1'b0, "R8", {31'd0, irq_o}, '0);
    @(negedge clk) rst_ni = 1'b1;

    rd_reg(2'd2, "R8");
    rd_reg(2'd3, "R6");
    wr_reg(2'd3, 32'hFFFF_FFFF, "R6");
    rd_reg(2'd3, "R6");

    // fill left, then overrun
    step(1, 24'h000011, 0, '0, 0, 0, 2'd0, '0, "R1");
    step(1, 24'h000022, 0, '0, 0, 0, 2'd0, '0, "R1");
    rd_reg(2'd2, "R5");
    step(1, 24'h000033, 0, '0, 0, 0, 2'd0, '0, "R1");
    step(1, 24'h000044, 0, '0, 0, 0, 2'd0, '0, "R1");
    rd_reg(2'd2, "R5");
    step(1, 24'h000055, 0, '0, 0, 0, 2'd0, '0, "R3");
    rd_reg(2'd2, "R3");
    for (int i = 0; i < 4; i++) rd_reg(2'd0, "R1");
    rd_reg(2'd0, "R2");
    rd_reg(2'd1, "R2");
    rd_reg(2'd2, "R2");
    idle("R1");

    // unmask everything
    wr_reg(2'd3, 32'h0000_0000, "R7");
    wr_reg(2'd2, 32'h0000_0000, "R4");
    rd_reg(2'd2, "R4");

    // fill right, clear in the same cycle as an overrun
    for (int i = 0; i < 4; i++) step(0, '0, 1, 24'hA00000 + 24'(i), 0, 0, 2'd0, '0, "R5");
    step(0, '0, 1, 24'hBADBAD, 1, 1, 2'd2, 32'hFFFF_FFFF, "R4");
    rd_reg(2'd2, "R4");
    wr_reg(2'd2, 32'h1234_5678, "R4");
    rd_reg(2'd2, "R4");

    // push while full with pop: push still dropped
    step(0, '0, 1, 24'h0000EE, 1, 0, 2'd1, '0, "R9");
    rd_reg(2'd2, "R9");
    // non-full push and pop together
    step(0, '0, 1, 24'h0000FF, 1, 0, 2'd1, '0, "R9");
    rd_reg(2'd2, "R9");
    // pop from empty left with push in same cycle
    step(1, 24'h000077, 0, '0, 1, 0, 2'd0, '0, "R9");
    rd_reg(2'd2, "R9");
    rd_reg(2'd0, "R9");
    for (int i = 0; i < 4; i++) rd_reg(2'd1, "R1");
    wr_reg(2'd3, 32'h0000_03FF, "R6");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic lv, rv, req, we;
      logic [1:0] a;
      logic [31:0] wd;
      string tag;
      lv  = ($urandom % 3) == 0;
      rv  = ($urandom % 3) == 0;
      req = ($urandom % 2) == 0;
      a   = 2'($urandom % 4);
      we  = req && (a >= 2'd2) && (($urandom % 4) == 0);
      wd  = $urandom;
      if (!req)          tag = "R1";
      else if (a <= 2'd1) tag = "R1";
      else if (a == 2'd2) tag = we ? "R4" : "R5";
      else               tag = "R6";
      step(lv, DW'($urandom), rv, DW'($urandom), req, we, a, wd, tag);
    end

    idle("R1");
    report();
  end
endmodule